// File: doc/BRIEF.md
# Presettable synchronous binary counter

A four-bit up-counter that counts in natural binary modulo 16. It can be preset in parallel and is built to be chained into wider counters. On each rising clock edge it does one of four things: it clears, it loads a value from a four-bit data bus, it increments, or it holds. The control inputs pick the action, and the priority among them is fixed.

Counting needs two enables, and they play different roles. The parallel enable gates counting only. The trickle enable gates counting and also qualifies the terminal-count flag. In a chain, the flag of one stage feeds the trickle enable of the next stage, and a shared enable goes to every stage's parallel enable. The clear is active-low, and it is asynchronous or synchronous according to the elaboration parameter `ASYNC_RESET`.

Top module: `sync_bin_counter`

## Requirements
- R1: While counting, the count goes 0, 1, 2 … 15 and then wraps from 15 (4'b1111) to 0 on the next counting edge.
- R2: With ASYNC_RESET=1, a low on `rst_n` forces `q` to 0 at once, with no clock edge, and keeps it there whatever the other inputs are.
- R3: With ASYNC_RESET=0, a low on `rst_n` leaves `q` unchanged until the next rising edge. That edge clears `q` to 0, overriding both load and count.
- R4: The priority is fixed: clear first, then load, then count, then hold. A load requested while both enables are high loads the data and does not increment.
- R5: With `rst_n` high and `load_n` low, a rising edge copies `din` into `q` (bit 0 to bit 0), whatever the enables are.
- R6: With `rst_n` and `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to `q`.
- R7: With `rst_n` and `load_n` high and either enable low, `q` holds its value across rising edges.
- R8: `tc` is combinational. It is 1 exactly when `en_trk` is 1 and `q` is 15, and `en_par` has no effect on it.
- R9: Two stages cascade into an 8-bit counter. Stage 0's `tc` drives stage 1's `en_trk`, and a common enable drives both `en_par` inputs. The pair then counts 0 through 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Active-low clear (asynchronous or synchronous per ASYNC_RESET) |
| load_n | input | 1 | Active-low parallel load request |
| din | input | 4 | Parallel preset data |
| en_par | input | 1 | Count enable that gates counting only |
| en_trk | input | 1 | Count enable that also qualifies `tc` |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
The bench builds both clear variants side by side. Right after a mid-cycle drop of `rst_n`, the asynchronous counter must already read zero while the synchronous one still shows its old value, so a design with the clear style swapped fails at once. The bench loads 15 with both enables high and checks that the load beats the increment and that the following counting edge wraps to 0. A priority mix-up, or a wrap that fails to roll over, shows up here. It also toggles each enable on its own at count 15: a `tc` tied to the wrong enable, or a design that counts with only one enable high, shows a wrong flag or a moving count. Last, a two-stage chain is stepped through all 256 values, which catches a carry that is late or missing at each stage boundary.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int CNT_W   = 4;
  localparam int MODE_W  = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_CLR  = 2'd3
  } cnt_mode_e;

  localparam cnt_t CNT_MAX = {CNT_W{1'b1}};
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      rst_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output cnt_mode_e mode
);
  logic cnt_en;

  assign cnt_en = en_par & en_trk;

  // Fixed priority: clear, load, increment, hold.
  always_comb begin
    if (!rst_n)       mode = MODE_CLR;
    else if (!load_n) mode = MODE_LOAD;
    else if (cnt_en)  mode = MODE_INC;
    else              mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
(
  input  cnt_mode_e mode,
  input  cnt_t      q_cur,
  input  cnt_t      din,
  output cnt_t      q_nxt,
  output logic      upd
);
  always_comb begin
    q_nxt = q_cur;
    upd   = 1'b1;
    unique case (mode)
      MODE_CLR:  q_nxt = '0;
      MODE_LOAD: q_nxt = din;
      MODE_INC:  q_nxt = q_cur + cnt_t'(1);
      default: begin
        q_nxt = q_cur;
        upd   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  cnt_t d,
  output cnt_t q
);
  generate
    if (ASYNC_RESET) begin : g_async_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= d;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec
  import cnt_pkg::*;
(
  input  cnt_t q,
  input  logic en_trk,
  output logic tc
);
  assign tc = en_trk & (q == CNT_MAX);
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import cnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_n,
  input  logic [cnt_pkg::CNT_W-1:0]  din,
  input  logic                       en_par,
  input  logic                       en_trk,
  output logic [cnt_pkg::CNT_W-1:0]  q,
  output logic                       tc
);
  cnt_mode_e mode;
  cnt_t      q_nxt;
  cnt_t      q_reg;
  logic      upd;

  cnt_mode_dec u_mode (
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  cnt_next u_next (
    .mode  (mode),
    .q_cur (q_reg),
    .din   (din),
    .q_nxt (q_nxt),
    .upd   (upd)
  );

  cnt_state_reg #(.ASYNC_RESET(ASYNC_RESET)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .d     (q_nxt),
    .q     (q_reg)
  );

  cnt_term_dec u_tc (
    .q      (q_reg),
    .en_trk (en_trk),
    .tc     (tc)
  );

  assign q = q_reg;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load_n,
  input logic [3:0] din,
  input logic       en_par,
  input logic       en_trk,
  input logic [3:0] q,
  input logic       tc
);
  logic clr_seen;

  always_ff @(posedge clk) clr_seen <= !rst_n;

  always @(negedge clk) begin
    if (clr_seen === 1'b1) begin
      AST_CLEAR_ZERO: assert (q == 4'd0) else $error("clear did not zero count"); // R2 R3
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && q == 4'hF) |=> (q == 4'd0)); // R1

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (q == $past(din))); // R5

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> (q == 4'($past(q) + 4'd1))); // R6

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q)); // R7

  AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc == (en_trk && q == 4'hF)); // R8
endmodule

bind sync_bin_counter cnt_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_n (load_n),
  .din    (din),
  .en_par (en_par),
  .en_trk (en_trk),
  .q      (q),
  .tc     (tc)
);

// File: tb/sim_sync_bin_counter.sv
`timescale 1ns/1ps
module sim_sync_bin_counter;
  logic       clk = 1'b0;
  logic       rst_a = 1'b0;
  logic       rst_s = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [3:0] q0, q1;
  logic       tc0, tc1;

  logic       c_rst = 1'b0;
  logic       c_ce = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sync_bin_counter #(.ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_a), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q0), .tc(tc0));

  sync_bin_counter #(.ASYNC_RESET(1'b0)) u1 (
    .clk(clk), .rst_n(rst_s), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q1), .tc(tc1));

  sync_bin_counter u_lo (
    .clk(clk), .rst_n(c_rst), .load_n(1'b1), .din(4'd0),
    .en_par(c_ce), .en_trk(c_ce), .q(lo_q), .tc(lo_tc));

  sync_bin_counter u_hi (
    .clk(clk), .rst_n(c_rst), .load_n(1'b1), .din(4'd0),
    .en_par(c_ce), .en_trk(lo_tc), .q(hi_q), .tc(hi_tc));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_a = 1'b0; rst_s = 1'b0;
    step();
    check("R2 reset q async", q0, 0);
    check("R3 reset q sync", q1, 0);
    check("R8 reset tc", tc0, 0);
    rst_a = 1'b1; rst_s = 1'b1;
  endtask

  task automatic t_clear_styles();
    din = 4'd9; load_n = 1'b0;
    step();
    load_n = 1'b1;
    check("R5 load 9 async", q0, 9);
    check("R5 load 9 sync", q1, 9);
    #2;
    rst_a = 1'b0; rst_s = 1'b0;
    load_n = 1'b0; din = 4'd6; en_par = 1'b1; en_trk = 1'b1;
    #1;
    check("R2 immediate clear", q0, 0);
    check("R3 no clear before edge", q1, 9);
    step();
    check("R3 clear on edge over load", q1, 0);
    check("R2 clear holds over load", q0, 0);
    rst_a = 1'b1; rst_s = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
  endtask

  task automatic t_load_ignores_enables();
    din = 4'd5; load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0;
    step();
    check("R5 load with enables low", q0, 5);
    din = 4'd10; en_par = 1'b1; en_trk = 1'b0;
    step();
    check("R5 load with one enable", q1, 10);
    load_n = 1'b1;
  endtask

  task automatic t_count_and_hold();
    din = 4'd3; load_n = 1'b0;
    step();
    load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      check("R6 increment", q0, 3 + k);
    end
    check("R6 increment sync variant", q1, 6);
    en_par = 1'b0; en_trk = 1'b1;
    step();
    check("R7 hold en_par low", q0, 6);
    en_par = 1'b1; en_trk = 1'b0;
    step();
    check("R7 hold en_trk low", q0, 6);
    en_par = 1'b0; en_trk = 1'b0;
    step();
    check("R7 hold both low", q1, 6);
  endtask

  task automatic t_load_over_count_and_wrap();
    din = 4'd15; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1;
    step();
    check("R4 load beats count", q0, 15);
    check("R8 tc at 15", tc0, 1);
    load_n = 1'b1;
    step();
    check("R1 wrap to 0", q0, 0);
    check("R1 wrap to 0 sync", q1, 0);
    check("R8 tc drops after wrap", tc0, 0);
  endtask

  task automatic t_tc_qualify();
    din = 4'd15; load_n = 1'b0;
    step();
    load_n = 1'b1; en_par = 1'b0; en_trk = 1'b1;
    #1;
    check("R8 tc ignores en_par", tc0, 1);
    en_trk = 1'b0; en_par = 1'b1;
    #1;
    check("R8 tc gated by en_trk", tc0, 0);
    step();
    check("R7 hold at 15", q0, 15);
    en_par = 1'b0;
  endtask

  task automatic t_cascade();
    c_rst = 1'b0;
    step();
    check("R9 cascade reset", {hi_q, lo_q}, 0);
    c_rst = 1'b1; c_ce = 1'b1;
    for (int k = 1; k <= 256; k++) begin
      step();
      check("R9 cascade value", {hi_q, lo_q}, k % 256);
      if (k == 255) check("R9 top tc at 255", hi_tc, 1);
    end
    check("R9 top tc after wrap", hi_tc, 0);
    c_ce = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_clear_styles();
    t_load_ignores_enables();
    t_count_and_hold();
    t_load_over_count_and_wrap();
    t_tc_qualify();
    t_cascade();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule